// File: doc/BRIEF.md
# Page-Mode Parallel NOR Read Controller

This block sits on the host side of an asynchronous parallel NOR memory that supports fast reads within a page. A client hands it one read at a time: a byte address, a byte/word mode flag and a valid strobe. The controller accepts the read when it is ready, drives the memory's select, read-enable, write-enable, width-select and address pins, waits the required number of clock cycles and captures the data bus. It then returns the data with a one-cycle valid pulse.

The controller remembers which page is open. A page is eight words, or sixteen bytes in byte mode, and is selected by request address bits 4 and up. A read that lands in the open page, with the memory still selected and in the same mode, waits only the short in-page time. A read to any other page, or the first read after the memory was deselected, waits the full random access time. In byte mode only the low eight data lines carry data, and the topmost data pin is driven by the controller as the extra least significant address bit. The memory holds array data after reset, so the first read needs no command.

Named states: IDLE (memory deselected, ready), ACCESS (memory selected, counting the access window, not ready), OPEN (memory selected, page valid, ready), DESELECT (memory deselected for the minimum high time, not ready). Transitions: IDLE to ACCESS on an accepted read. OPEN to ACCESS on an accepted read in the same mode, with the page time on a page hit and the full time on a miss. OPEN to DESELECT on an accepted read with the other mode (the read is held pending) or on idle timeout. ACCESS to OPEN when the window ends, which issues the response. DESELECT to ACCESS when the high time ends with a read pending, otherwise DESELECT to IDLE.

Top module: `pflash_reader`

## Requirements
- R1: After reset, fm_sel_n, fm_rd_n and fm_wr_n are 1, fm_wide is 1 (word mode), req_ready is 1, rsp_valid is 0 and no page is open.
- R2: fm_wr_n is always 1. Whenever fm_sel_n is 0, fm_rd_n is 0 too. From the cycle after a read is accepted, fm_addr equals req_addr[ADDR_W:1] and stays unchanged for the whole access window.
- R3: A read accepted while no page is open (after reset or after a deselect) gives rsp_valid exactly T_ACC cycles after the accepting clock edge.
- R4: A read accepted while the memory is selected, in the same mode and with the same req_addr[ADDR_W:4] as the open page, gives rsp_valid exactly T_PAGE cycles after acceptance.
- R5: A read accepted while the memory is selected, in the same mode but on a different page, keeps the memory selected and gives rsp_valid T_ACC cycles after acceptance.
- R6: In byte mode (req_byte=1), fm_wide is 0, fm_lsb_oe is 1 and fm_lsb_out carries req_addr[0], and rsp_data is {8'h00, fm_dq_in[7:0]}. In word mode, fm_lsb_oe is 0 and rsp_data is fm_dq_in[15:0].
- R7: After IDLE_LIMIT consecutive cycles in OPEN without an accepted read, fm_sel_n goes to 1 and the page is closed, so the next read takes T_ACC even within the same page.
- R8: A read accepted in OPEN whose mode differs from the open mode deselects the memory for T_CEH cycles and then performs a full access, so rsp_valid comes T_CEH + T_ACC cycles after acceptance.
- R9: Every period with fm_sel_n at 1 between two selected periods lasts at least T_CEH cycles.
- R10: req_ready is 0 during ACCESS and DESELECT. Each accepted read produces exactly one single-cycle rsp_valid pulse, in acceptance order.
- R11: In word mode, req_addr[0] has no effect on fm_addr, on timing or on rsp_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request strobe |
| req_ready | output | 1 | Controller can accept a read this cycle |
| req_addr | input | ADDR_W+1 | Byte address; bit 0 is used only in byte mode |
| req_byte | input | 1 | 1 = byte mode, 0 = word mode |
| rsp_valid | output | 1 | One-cycle pulse, rsp_data is valid |
| rsp_data | output | BUS_W | Read data (upper half zero in byte mode) |
| fm_sel_n | output | 1 | Memory select, active low |
| fm_rd_n | output | 1 | Memory output enable, active low |
| fm_wr_n | output | 1 | Memory write enable, held high |
| fm_wide | output | 1 | Width select: 1 word, 0 byte |
| fm_addr | output | ADDR_W | Word address to the memory |
| fm_dq_in | input | BUS_W | Data bus sampled from the memory |
| fm_lsb_out | output | 1 | Value for the top data pin used as the lowest address bit in byte mode |
| fm_lsb_oe | output | 1 | Drive enable for the top data pin |

## Verification
The assertions assume the client holds req_addr and req_byte steady while req_valid is high and not yet accepted, and that it issues a new request only through the ready handshake. They also assume the timing parameters are at least 1 and IDLE_LIMIT is at least 2. The bench keeps to this by driving requests at the falling edge, holding them until it sees req_ready high, and dropping req_valid right after the accepting edge. Its memory model returns correct data only once select, mode, page and in-page address have been stable for the required number of cycles. A controller that samples too early therefore returns a visible wrong value instead of relying on an assertion to catch it.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ACCESS   = 2'd1,
        ST_OPEN     = 2'd2,
        ST_DESELECT = 2'd3
    } pfr_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pflash_cycle_timer.sv
module pflash_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CNT_W'(1));

    // A zero window would never end the wait.
    AST_TMR_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R3

    AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1)); // R3

endmodule

// File: rtl/pflash_page_tag.sv
module pflash_page_tag #(
    parameter int PAGE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set,
    input  logic [PAGE_W-1:0] set_page,
    input  logic              set_mode,
    input  logic [PAGE_W-1:0] cmp_page,
    input  logic              cmp_mode,
    output logic              valid,
    output logic              hit,
    output logic              mode_same
);

    logic [PAGE_W-1:0] page_q;
    logic              mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            page_q <= '0;
            mode_q <= 1'b0;
        end else if (clr) begin
            valid  <= 1'b0;
        end else if (set) begin
            valid  <= 1'b1;
            page_q <= set_page;
            mode_q <= set_mode;
        end
    end

    assign hit       = valid && (page_q == cmp_page);
    assign mode_same = valid && (mode_q == cmp_mode);

    AST_TAG_NO_DOUBLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && set)); // R7

endmodule

// File: rtl/pflash_idle_watch.sv
module pflash_idle_watch #(
    parameter int IDLE_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int IW = $clog2(IDLE_LIMIT + 1);

    logic [IW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == IW'(IDLE_LIMIT - 1));

    AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < IW'(IDLE_LIMIT)); // R7

endmodule

// File: rtl/pflash_reader.sv
module pflash_reader
    import pflash_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int BUS_W      = 16,
    parameter int T_ACC      = 11,
    parameter int T_PAGE     = 3,
    parameter int T_CEH      = 2,
    parameter int IDLE_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W:0]   req_addr,
    input  logic              req_byte,
    output logic              rsp_valid,
    output logic [BUS_W-1:0]  rsp_data,
    output logic              fm_sel_n,
    output logic              fm_rd_n,
    output logic              fm_wr_n,
    output logic              fm_wide,
    output logic [ADDR_W-1:0] fm_addr,
    input  logic [BUS_W-1:0]  fm_dq_in,
    output logic              fm_lsb_out,
    output logic              fm_lsb_oe
);

    localparam int HALF_W = BUS_W / 2;
    localparam int PAGE_W = ADDR_W - 3;
    localparam int MAXT   = max3(T_ACC, T_PAGE, T_CEH);
    localparam int CNT_W  = $clog2(MAXT + 1);

    pfr_state_e state, nxt;

    logic              accept;
    logic [PAGE_W-1:0] req_page;
    logic [PAGE_W-1:0] cur_page;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic [CNT_W-1:0]  tmr_cnt;
    logic              tmr_last;

    logic              tag_clr;
    logic              tag_set;
    logic [PAGE_W-1:0] set_page;
    logic              set_mode;
    logic              tag_valid;
    logic              tag_hit;
    logic              tag_mode_same;

    logic              idle_run;
    logic              idle_exp;

    logic              cap_req;
    logic              pend_set;
    logic              pend_clr;
    logic              pend_q;
    logic              rsp_fire;

    logic [ADDR_W-1:0] addr_q;
    logic              lsb_q;
    logic              byte_q;
    logic              rsp_valid_q;
    logic [BUS_W-1:0]  rsp_data_q;
    logic [BUS_W-1:0]  sampled;

    assign accept   = req_valid && req_ready;
    assign req_page = req_addr[ADDR_W:4];
    assign cur_page = addr_q[ADDR_W-1:3];
    assign idle_run = (state == ST_OPEN) && !accept;

    pflash_cycle_timer #(
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .last     (tmr_last)
    );

    pflash_page_tag #(
        .PAGE_W    (PAGE_W)
    ) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tag_clr),
        .set       (tag_set),
        .set_page  (set_page),
        .set_mode  (set_mode),
        .cmp_page  (req_page),
        .cmp_mode  (req_byte),
        .valid     (tag_valid),
        .hit       (tag_hit),
        .mode_same (tag_mode_same)
    );

    pflash_idle_watch #(
        .IDLE_LIMIT (IDLE_LIMIT)
    ) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (idle_run),
        .expired    (idle_exp)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transition and control decode
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tag_clr  = 1'b0;
        tag_set  = 1'b0;
        set_page = req_page;
        set_mode = req_byte;
        cap_req  = 1'b0;
        pend_set = 1'b0;
        pend_clr = 1'b0;
        rsp_fire = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    nxt      = ST_ACCESS;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_ACC);
                    cap_req  = 1'b1;
                    tag_set  = 1'b1;
                end
            end
            ST_OPEN: begin
                if (accept) begin
                    cap_req = 1'b1;
                    if (!tag_mode_same) begin
                        nxt      = ST_DESELECT;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_CEH);
                        tag_clr  = 1'b1;
                        pend_set = 1'b1;
                    end else if (tag_hit) begin
                        nxt      = ST_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_PAGE);
                        tag_set  = 1'b1;
                    end else begin
                        nxt      = ST_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_ACC);
                        tag_set  = 1'b1;
                    end
                end else if (idle_exp) begin
                    nxt      = ST_DESELECT;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_CEH);
                    tag_clr  = 1'b1;
                end
            end
            ST_ACCESS: begin
                if (tmr_last) begin
                    nxt      = ST_OPEN;
                    rsp_fire = 1'b1;
                end
            end
            ST_DESELECT: begin
                if (tmr_last) begin
                    pend_clr = 1'b1;
                    if (pend_q) begin
                        nxt      = ST_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_ACC);
                        tag_set  = 1'b1;
                        set_page = cur_page;
                        set_mode = byte_q;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Request capture and pending flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            lsb_q  <= 1'b0;
            byte_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (cap_req) begin
                addr_q <= req_addr[ADDR_W:1];
                lsb_q  <= req_addr[0];
                byte_q <= req_byte;
            end
            if (pend_set) begin
                pend_q <= 1'b1;
            end else if (pend_clr) begin
                pend_q <= 1'b0;
            end
        end
    end

    // Data capture: the top half is masked in byte mode
    always_comb begin
        if (byte_q) begin
            sampled = {{(BUS_W-HALF_W){1'b0}}, fm_dq_in[HALF_W-1:0]};
        end else begin
            sampled = fm_dq_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= rsp_fire;
            if (rsp_fire) begin
                rsp_data_q <= sampled;
            end
        end
    end

    // Output decode
    always_comb begin
        req_ready  = 1'b0;
        fm_sel_n   = 1'b1;
        fm_rd_n    = 1'b1;
        fm_wr_n    = 1'b1;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_OPEN: begin
                req_ready = 1'b1;
                fm_sel_n  = 1'b0;
                fm_rd_n   = 1'b0;
            end
            ST_ACCESS: begin
                fm_sel_n  = 1'b0;
                fm_rd_n   = 1'b0;
            end
            ST_DESELECT: begin
                req_ready = 1'b0;
            end
            default: req_ready = 1'b0;
        endcase
        fm_wide    = !byte_q;
        fm_addr    = addr_q;
        fm_lsb_oe  = byte_q;
        fm_lsb_out = byte_q && lsb_q;
        rsp_valid  = rsp_valid_q;
        rsp_data   = rsp_data_q;
    end

    // Assertions
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && $past(state) == ST_ACCESS)
            |-> ($stable(fm_addr) && $stable(fm_lsb_out) && $stable(fm_wide))); // R2

    AST_PAGE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state == ST_OPEN && tag_hit && tag_mode_same)
            |=> (tmr_cnt == CNT_W'(T_PAGE))); // R4

    AST_MISS_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state == ST_OPEN && tag_mode_same && !tag_hit)
            |=> (!fm_sel_n && tmr_cnt == CNT_W'(T_ACC))); // R5

    AST_SEL_CLOSES_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        fm_sel_n |-> !tag_valid); // R7

    AST_MODE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state == ST_OPEN && req_byte != byte_q) |=> fm_sel_n); // R8

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10

    AST_RSP_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (state == ST_OPEN && !fm_sel_n)); // R10

    generate
        if (T_CEH >= 2) begin : g_ceh_chk
            AST_CEH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(fm_sel_n) |=> fm_sel_n); // R9
        end
    endgenerate

endmodule

// File: tb/pflash_reader_bench.sv
module pflash_reader_bench;

    localparam int AW     = 24;
    localparam int T_ACC  = 11;
    localparam int T_PAGE = 3;
    localparam int T_CEH  = 2;
    localparam int IDLE_L = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW:0]   req_addr = '0;
    logic          req_byte = 1'b0;
    logic          rsp_valid;
    logic [15:0]   rsp_data;
    logic          fm_sel_n, fm_rd_n, fm_wr_n, fm_wide;
    logic [AW-1:0] fm_addr;
    logic [15:0]   fm_dq_in = 16'hDEAD;
    logic          fm_lsb_out, fm_lsb_oe;

    int errors = 0;
    int checks = 0;
    longint cyc = 0;
    bit     mon_on = 1'b0;

    longint due_q[$];
    logic [15:0] dat_q[$];
    string  tag_q[$];

    bit          m_open = 1'b0;
    logic [AW-4:0] m_page = '0;
    logic        m_mode = 1'b0;
    longint      r_prev = 0;

    pflash_reader #(
        .ADDR_W(AW), .BUS_W(16), .T_ACC(T_ACC), .T_PAGE(T_PAGE),
        .T_CEH(T_CEH), .IDLE_LIMIT(IDLE_L)
    ) u_pflash_reader (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .fm_sel_n(fm_sel_n), .fm_rd_n(fm_rd_n),
        .fm_wr_n(fm_wr_n), .fm_wide(fm_wide), .fm_addr(fm_addr),
        .fm_dq_in(fm_dq_in), .fm_lsb_out(fm_lsb_out), .fm_lsb_oe(fm_lsb_oe)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] memw(input logic [AW-1:0] wa);
        return wa[15:0] ^ {wa[7:0], wa[15:8]} ^ 16'h5A3C ^ {8'h00, wa[23:16]};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Memory model: data is correct only after enough stable cycles
    logic [AW+1:0] prev_a = '1;
    logic [AW+1:0] prev_p = '1;
    int run_a = 0;
    int run_p = 0;
    always @(negedge clk) begin
        logic [AW+1:0] ka, kp;
        logic [15:0] w;
        ka = {3'b000, fm_wide, fm_addr[AW-1:3]};
        kp = {fm_wide, fm_addr, (!fm_wide) ? fm_lsb_out : 1'b0};
        if (fm_sel_n || fm_rd_n) begin
            run_a = 0; run_p = 0;
        end else begin
            run_a = (ka != prev_a || run_a == 0) ? 1 : run_a + 1;
            run_p = (kp != prev_p || run_p == 0) ? 1 : run_p + 1;
        end
        prev_a = ka; prev_p = kp;
        w = memw(fm_addr);
        if (run_a >= T_ACC && run_p >= T_PAGE) begin
            if (fm_wide) fm_dq_in = w;
            else fm_dq_in = {8'hEE, fm_lsb_out ? w[15:8] : w[7:0]};
        end else begin
            fm_dq_in = 16'hDEAD;
        end
    end

    // Per-cycle comparison against the reference queue
    int sel_hi = 0;
    bit seen_sel = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                chk(rsp_valid == 1'b1, {tag_q[0], " R10 rsp_valid"}, rsp_valid, 1);
                chk(rsp_data == dat_q[0], {tag_q[0], " R6 rsp_data"}, rsp_data, dat_q[0]);
                void'(due_q.pop_front()); void'(dat_q.pop_front()); void'(tag_q.pop_front());
            end else if (rsp_valid) begin
                chk(1'b0, "R10 unexpected rsp_valid", rsp_valid, 0);
            end
            if (fm_wr_n !== 1'b1) chk(1'b0, "R2 fm_wr_n", fm_wr_n, 1);
            if (!fm_sel_n && fm_rd_n) chk(1'b0, "R2 fm_rd_n with select", fm_rd_n, 0);
            if (fm_lsb_oe != !fm_wide) chk(1'b0, "R6 fm_lsb_oe", fm_lsb_oe, !fm_wide);
            if (fm_sel_n) sel_hi++;
            else begin
                if (seen_sel && sel_hi > 0)
                    chk(sel_hi >= T_CEH, "R9 select high time", sel_hi, T_CEH);
                seen_sel = 1'b1;
                sel_hi = 0;
            end
        end
    end

    task automatic do_read(input logic [AW:0] a, input logic bm, input int gap);
        longint acc_c, lat, j;
        bit open_now;
        string tg;
        logic [15:0] w, ex;
        repeat (gap) @(negedge clk);
        req_addr = a; req_byte = bm; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        acc_c = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        j = acc_c - r_prev;
        open_now = m_open && (j <= IDLE_L);
        if (!open_now) begin lat = T_ACC; tg = "R3"; end
        else if (bm != m_mode) begin lat = T_CEH + T_ACC; tg = "R8"; end
        else if (a[AW:4] == m_page) begin lat = T_PAGE; tg = "R4"; end
        else begin lat = T_ACC; tg = "R5"; end
        m_open = 1'b1; m_page = a[AW:4]; m_mode = bm; r_prev = acc_c + lat;
        w = memw(a[AW:1]);
        ex = bm ? {8'h00, (a[0] ? w[15:8] : w[7:0])} : w;
        due_q.push_back(acc_c + lat); dat_q.push_back(ex); tag_q.push_back(tg);
        chk(fm_addr == a[AW:1], "R2 fm_addr", fm_addr, a[AW:1]);
        chk(req_ready == 1'b0, "R10 not ready in flight", req_ready, 0);
        if (bm) begin
            chk(fm_wide == 1'b0 && fm_lsb_out == a[0], "R6 byte pins",
                {fm_wide, fm_lsb_out}, {1'b0, a[0]});
        end
    endtask

    task automatic drain();
        while (due_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [AW:0] base0, base1, base2;
        logic [15:0] d0;
        base0 = 25'h0123_450; base1 = 25'h0ABC_DE0; base2 = 25'h1F0_0000;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(fm_sel_n && fm_rd_n && fm_wr_n, "R1 pins in reset", {fm_sel_n, fm_rd_n, fm_wr_n}, 3'b111);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(fm_wide == 1'b1, "R1 word mode", fm_wide, 1);
        chk(fm_sel_n == 1'b1, "R1 deselected", fm_sel_n, 1);
        mon_on = 1'b1;

        // R3 first access, R4 hits, R5 miss
        do_read(base0 | 25'h4, 1'b0, 0);
        do_read(base0 | 25'hE, 1'b0, 0);
        do_read(base0 | 25'h2, 1'b0, 2);
        do_read(base1 | 25'h6, 1'b0, 0);
        chk(fm_sel_n == 1'b0, "R5 select held on miss", fm_sel_n, 0);
        // R11: bit 0 ignored in word mode
        do_read(base1 | 25'h6, 1'b0, 0);
        do_read(base1 | 25'h7, 1'b0, 0);
        chk(fm_lsb_oe == 1'b0, "R11 top pin not driven", fm_lsb_oe, 0);
        drain();
        d0 = memw(base1[AW:1] | 24'h3);
        chk(d0 == memw((base1 | 25'h7) >> 1), "R11 same word", d0, memw((base1 | 25'h7) >> 1));

        // R8 mode switch, R6 byte reads
        do_read(base1 | 25'h9, 1'b1, 0);
        do_read(base1 | 25'h8, 1'b1, 0);
        do_read(base1 | 25'hF, 1'b1, 1);
        drain();

        // R7 idle timeout closes the page
        repeat (IDLE_L + T_CEH + 4) @(negedge clk);
        chk(fm_sel_n == 1'b1, "R7 deselect after idle", fm_sel_n, 1);
        do_read(base1 | 25'hE, 1'b1, 0);
        do_read(base2 | 25'h3, 1'b0, 0);
        drain();

        // Mixed traffic
        for (int k = 0; k < 80; k++) begin
            logic [AW:0] b, a;
            logic bm;
            int g;
            case ($urandom_range(0, 2))
                0: b = base0;
                1: b = base1;
                default: b = base2;
            endcase
            a  = b | 25'($urandom_range(0, 15));
            bm = ($urandom_range(0, 4) == 0) ? !m_mode : m_mode;
            g  = ($urandom_range(0, 9) == 0) ? IDLE_L + T_CEH + 3 : $urandom_range(0, 3);
            do_read(a, bm, g);
        end
        drain();
        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule